// File: doc/BRIEF.md
# Panel Timing Generator

This block produces the raster timing for a display panel: horizontal and vertical sync, a data-enable strobe and the coordinates of the pixel being shown. Panel dimensions come from one packed size word. Sync, back-porch and front-porch lengths come from one packed timing word for each axis. All of these words are captured at the start of every frame, so software may rewrite them at any time without tearing the frame in progress.

The generator has two modes. In continuous mode it emits frames back to back while `run_en` is high, and it can optionally freeze at a frame boundary while a halt request is held. In command mode a pulse on `start_req` produces exactly one frame. That frame can be held back until the next rising edge of a tearing-effect signal, which is taken either from an external pad or from an internal source.

For an interrupt block, the generator raises single-cycle events at the start of vsync, at the first active pixel, at the last clock of the frame and on each tearing-effect edge. It also raises an underflow flag whenever pixel data is not valid during the active area.

Top module: `panel_timing_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `busy`, `hsync`, `vsync`, `de`, all event outputs, `x` and `y` are all zero.
- R2: The active width is taken from `panel_size[15:0]` and the active height from `panel_size[31:16]`. Each timing word holds the sync length in bits [7:0], the back porch in bits [19:8] and the front porch in bits [31:20]. Horizontal lengths are counted in clocks and vertical lengths in lines. A field of zero counts as one.
- R3: Every line runs in this order: sync, back porch, active, front porch. `hsync` is high (active-high) during the sync clocks only. `x` counts from 0 to width-1 during the horizontal active clocks and is 0 at all other times.
- R4: Every frame runs the same four phases, in the same order, in whole lines. `vsync` is high for whole sync lines. `y` counts from 0 to height-1 during the active lines and is 0 at all other times.
- R5: `de` is high exactly when both axes are in their active phase.
- R6: In continuous mode (`cmd_mode`=0), a high `run_en` starts a frame on the next clock, and each frame is followed at once by the next one. If `run_en` is low at the last clock of a frame, the generator goes idle.
- R7: In command mode (`cmd_mode`=1), with gating off, a `start_req` pulse starts one frame on the next clock. After the last line of that frame the generator returns to idle.
- R8: `te_evt` pulses for one cycle in the second cycle after the selected tearing-effect source (`te_pad` when `te_from_pad`=1, otherwise `te_int`) is first seen high at a clock edge. With `te_gate_en`=1, a command-mode start waits, busy and without sync, until the next such pulse, and begins the frame on the following clock.
- R9: In continuous mode with `halt_en`=1, if `halt_in` is high at the last clock of a frame, the generator stays busy with all timing outputs low until `halt_in` drops. `halt_in` has no effect when `halt_en`=0 or in command mode.
- R10: The size and timing words and the mode are sampled only when a frame starts. A change in the middle of a frame takes effect from the next frame.
- R11: `vsync_evt` is high in the first clock of each frame, `frame_start` at the first active pixel (x=0, y=0) and `frame_end` in the last clock of the frame.
- R12: `underflow` is high in any cycle where `de` is high and `pix_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| panel_size | input | 32 | Active height [31:16], active width [15:0] |
| h_timing | input | 32 | Horizontal front porch [31:20], back porch [19:8], sync [7:0] |
| v_timing | input | 32 | Vertical front porch [31:20], back porch [19:8], sync [7:0] |
| cmd_mode | input | 1 | 1 = single frame per start request, 0 = continuous |
| run_en | input | 1 | Continuous-mode run enable |
| start_req | input | 1 | Command-mode frame request |
| te_gate_en | input | 1 | Make command frames wait for a tearing-effect edge |
| te_from_pad | input | 1 | Select the pad tearing-effect source |
| halt_en | input | 1 | Allow halting at frame boundaries |
| halt_in | input | 1 | Halt request |
| te_pad | input | 1 | Tearing-effect input from the pad |
| te_int | input | 1 | Internal tearing-effect source |
| pix_valid | input | 1 | Pixel data available |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| x | output | 16 | Active column |
| y | output | 16 | Active row |
| vsync_evt | output | 1 | Frame-start (vsync) event |
| frame_start | output | 1 | First active pixel event |
| frame_end | output | 1 | Last clock of frame event |
| te_evt | output | 1 | Tearing-effect edge event |
| underflow | output | 1 | Pixel data missing in the active area |
| busy | output | 1 | Generator not idle |

## Verification
The hardest situations to reach are the ones that exist only at a frame boundary: a halt request caught on the very last clock of a frame, a timing word rewritten while a frame is running, and a command start left parked while it waits for a tearing-effect edge. The stimulus uses tiny panels of a few dozen clocks per frame, so boundaries come quickly. It holds halt and rewrites the configuration across several whole frames, so the boundary is crossed with the request already in place. It pulses the source that is not selected before the selected one, to show that only the chosen source releases the waiting frame. A behavioural position model predicts every output on every clock, so a slip of one cycle at any boundary shows up at once.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    localparam int REG_W     = 32;
    localparam int SYNC_W    = 8;
    localparam int BACK_W    = 12;
    localparam int FRONT_W   = 12;
    localparam int ACT_W     = 16;
    localparam int BACK_LSB  = SYNC_W;
    localparam int FRONT_LSB = BACK_LSB + BACK_W;
    localparam int CNT_W     = ACT_W;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_WAIT_TE = 2'd1,
        FS_RUN     = 2'd2,
        FS_HALT    = 2'd3
    } fstate_t;

    typedef struct packed {
        logic [CNT_W-1:0] sync_len;
        logic [CNT_W-1:0] back_len;
        logic [CNT_W-1:0] act_len;
        logic [CNT_W-1:0] front_len;
    } axis_cfg_t;

    function automatic logic [CNT_W-1:0] min_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    function automatic axis_cfg_t unpack_axis(input logic [REG_W-1:0] t,
                                              input logic [ACT_W-1:0] act);
        axis_cfg_t c;
        c.sync_len  = min_one(CNT_W'(t[SYNC_W-1:0]));
        c.back_len  = min_one(CNT_W'(t[BACK_LSB +: BACK_W]));
        c.front_len = min_one(CNT_W'(t[FRONT_LSB +: FRONT_W]));
        c.act_len   = min_one(CNT_W'(act));
        return c;
    endfunction

endpackage

// File: rtl/ptg_axis_seq.sv
module ptg_axis_seq
    import ptg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output phase_t           phase,
    output logic [CNT_W-1:0] pos,
    output logic             first,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cur_len;
    phase_t           nxt_ph;

    always_comb begin
        unique case (phase)
            PH_SYNC:  begin cur_len = cfg.sync_len;  nxt_ph = PH_BACK;  end
            PH_BACK:  begin cur_len = cfg.back_len;  nxt_ph = PH_ACT;   end
            PH_ACT:   begin cur_len = cfg.act_len;   nxt_ph = PH_FRONT; end
            default:  begin cur_len = cfg.front_len; nxt_ph = PH_SYNC;  end
        endcase
    end

    assign first = (phase == PH_SYNC) && (pos == '0);
    assign last  = (phase == PH_FRONT) && (pos == cur_len - ONE);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            phase <= PH_SYNC;
            pos   <= '0;
        end else if (step) begin
            if (pos == cur_len - ONE) begin
                pos   <= '0;
                phase <= nxt_ph;
            end else begin
                pos <= pos + ONE;
            end
        end
    end
endmodule

// File: rtl/ptg_te_sync.sv
module ptg_te_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic from_pad,
    input  logic te_pad,
    input  logic te_int,
    output logic te_edge
);
    logic [STAGES:0] sh;
    logic            src;

    assign src = from_pad ? te_pad : te_int;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], src};
    end

    assign te_edge = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ptg_frame_fsm.sv
module ptg_frame_fsm
    import ptg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_mode,
    input  logic    run_en,
    input  logic    start_req,
    input  logic    te_gate_en,
    input  logic    te_edge,
    input  logic    halt_en,
    input  logic    halt_in,
    input  logic    frame_last,
    output fstate_t state,
    output logic    launch,
    output logic    lmode
);
    logic    halt_hold;
    fstate_t nxt;

    assign halt_hold = halt_en & halt_in;

    always_comb begin
        launch = 1'b0;
        nxt    = state;
        unique case (state)
            FS_IDLE: begin
                if (!cmd_mode) begin
                    launch = run_en;
                end else if (start_req) begin
                    if (te_gate_en) nxt = FS_WAIT_TE;
                    else            launch = 1'b1;
                end
            end
            FS_WAIT_TE: launch = te_edge;
            FS_RUN: begin
                if (frame_last) begin
                    if (!lmode && run_en && !halt_hold) launch = 1'b1;
                    else if (!lmode && run_en)          nxt = FS_HALT;
                    else                                nxt = FS_IDLE;
                end
            end
            default: begin
                if (!halt_hold) begin
                    if (run_en) launch = 1'b1;
                    else        nxt = FS_IDLE;
                end
            end
        endcase
        if (launch) nxt = FS_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            lmode <= 1'b0;
        end else begin
            state <= nxt;
            if (launch) lmode <= cmd_mode;
        end
    end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int TE_SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] panel_size,
    input  logic [REG_W-1:0] h_timing,
    input  logic [REG_W-1:0] v_timing,
    input  logic             cmd_mode,
    input  logic             run_en,
    input  logic             start_req,
    input  logic             te_gate_en,
    input  logic             te_from_pad,
    input  logic             halt_en,
    input  logic             halt_in,
    input  logic             te_pad,
    input  logic             te_int,
    input  logic             pix_valid,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [ACT_W-1:0] x,
    output logic [ACT_W-1:0] y,
    output logic             vsync_evt,
    output logic             frame_start,
    output logic             frame_end,
    output logic             te_evt,
    output logic             underflow,
    output logic             busy
);
    localparam int AX_N = 2;
    localparam int AX_H = 0;
    localparam int AX_V = 1;

    fstate_t fstate;
    logic    launch;
    logic    lmode;
    logic    running;
    logic    te_edge;
    logic    frame_last;

    axis_cfg_t [AX_N-1:0]            ax_cfg;
    phase_t    [AX_N-1:0]            ax_ph;
    logic      [AX_N-1:0][CNT_W-1:0] ax_pos;
    logic      [AX_N-1:0]            ax_step;
    logic      [AX_N-1:0]            ax_first;
    logic      [AX_N-1:0]            ax_last;
    logic      [AX_N-1:0]            ax_act;

    // configuration captured at frame launch only
    always_ff @(posedge clk) begin
        if (rst) begin
            ax_cfg[AX_H] <= unpack_axis('0, '0);
            ax_cfg[AX_V] <= unpack_axis('0, '0);
        end else if (launch) begin
            ax_cfg[AX_H] <= unpack_axis(h_timing, panel_size[ACT_W-1:0]);
            ax_cfg[AX_V] <= unpack_axis(v_timing, panel_size[REG_W-1 -: ACT_W]);
        end
    end

    assign running       = (fstate == FS_RUN);
    assign ax_step[AX_H] = running;
    assign ax_step[AX_V] = running & ax_last[AX_H];
    assign frame_last    = running & ax_last[AX_H] & ax_last[AX_V];

    for (genvar g = 0; g < AX_N; g++) begin : g_axis
        ptg_axis_seq u_seq (
            .clk   (clk),
            .rst   (rst),
            .load  (launch),
            .step  (ax_step[g]),
            .cfg   (ax_cfg[g]),
            .phase (ax_ph[g]),
            .pos   (ax_pos[g]),
            .first (ax_first[g]),
            .last  (ax_last[g])
        );
        assign ax_act[g] = running && (ax_ph[g] == PH_ACT);
    end

    ptg_te_sync #(.STAGES(TE_SYNC_STAGES)) u_te (
        .clk      (clk),
        .rst      (rst),
        .from_pad (te_from_pad),
        .te_pad   (te_pad),
        .te_int   (te_int),
        .te_edge  (te_edge)
    );

    ptg_frame_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_mode   (cmd_mode),
        .run_en     (run_en),
        .start_req  (start_req),
        .te_gate_en (te_gate_en),
        .te_edge    (te_edge),
        .halt_en    (halt_en),
        .halt_in    (halt_in),
        .frame_last (frame_last),
        .state      (fstate),
        .launch     (launch),
        .lmode      (lmode)
    );

    assign hsync       = running && (ax_ph[AX_H] == PH_SYNC);
    assign vsync       = running && (ax_ph[AX_V] == PH_SYNC);
    assign de          = ax_act[AX_H] & ax_act[AX_V];
    assign x           = ax_act[AX_H] ? ACT_W'(ax_pos[AX_H]) : '0;
    assign y           = ax_act[AX_V] ? ACT_W'(ax_pos[AX_V]) : '0;
    assign vsync_evt   = running & ax_first[AX_H] & ax_first[AX_V];
    assign frame_start = de && (ax_pos[AX_H] == '0) && (ax_pos[AX_V] == '0);
    assign frame_end   = frame_last;
    assign te_evt      = te_edge;
    assign underflow   = de & ~pix_valid;
    assign busy        = (fstate != FS_IDLE);
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
    import ptg_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    hsync,
    input logic    vsync,
    input logic    de,
    input logic    vsync_evt,
    input logic    frame_end,
    input logic    busy,
    input logic    te_evt,
    input logic    underflow,
    input logic    run_en,
    input logic    halt_en,
    input logic    halt_in,
    input logic    lmode,
    input fstate_t fstate
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !busy && !hsync && !de);

    // R5
    de_excl_sync_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> !hsync && !vsync);

    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !lmode && run_en && !(halt_en && halt_in)) |=> vsync_evt);

    // R7
    single_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_end && lmode) |=> !busy);

    // R8
    te_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (fstate == FS_WAIT_TE && !te_evt) |=> busy && !hsync);

    // R9
    halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (fstate == FS_HALT) |-> busy && !hsync && !vsync && !de);

    // R11
    vsync_evt_pos_chk: assert property (@(posedge clk) disable iff (rst)
        vsync_evt |-> hsync && vsync);

    // R12
    underflow_active_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> de);
endmodule

bind panel_timing_gen ptg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .vsync_evt (vsync_evt),
    .frame_end (frame_end),
    .busy      (busy),
    .te_evt    (te_evt),
    .underflow (underflow),
    .run_en    (run_en),
    .halt_en   (halt_en),
    .halt_in   (halt_in),
    .lmode     (lmode),
    .fstate    (fstate)
);

// File: tb/panel_timing_gen_test.sv
`timescale 1ns/1ps
module panel_timing_gen_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] panel_size, h_timing, v_timing;
    logic cmd_mode = 0, run_en = 0, start_req = 0, te_gate_en = 0, te_from_pad = 0;
    logic halt_en = 0, halt_in = 0, te_pad = 0, te_int = 0, pix_valid = 0;
    logic hsync, vsync, de, vsync_evt, frame_start, frame_end, te_evt, underflow, busy;
    logic [15:0] x, y;

    int vectors = 0, fails = 0, cyc = 0;
    bit done = 0;
    string scen = "R1 reset";

    // behavioural model state
    int m_st = 0, hpos = 0, vpos = 0, lcmd = 0;
    int Hs = 1, Hb = 1, Ha = 1, Hf = 1, Vs = 1, Vb = 1, Va = 1, Vf = 1;
    int t1 = 0, t2 = 0, t3 = 0;
    int hs_run = 0, last_hs = 0;

    always #4 clk = ~clk;

    panel_timing_gen uut (.*);

    function automatic int nz(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t: got %0d expected %0d", rst ? "R1" : tag, scen, $time, act, exp);
        end
    endtask

    task automatic check_dir(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s]: got %0d expected %0d", tag, scen, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int htot, vtot, hx, vy, nst, sel;
            bit e_run, hact, vact, e_de, e_te, e_fe, halt, launch;
            htot = Hs + Hb + Ha + Hf;
            vtot = Vs + Vb + Va + Vf;
            e_run = (m_st == 2);
            hact = (hpos >= Hs + Hb) && (hpos < Hs + Hb + Ha);
            vact = (vpos >= Vs + Vb) && (vpos < Vs + Vb + Va);
            hx = (e_run && hact) ? hpos - Hs - Hb : 0;
            vy = (e_run && vact) ? vpos - Vs - Vb : 0;
            e_de = e_run && hact && vact;
            e_te = (t2 == 1) && (t3 == 0);
            e_fe = e_run && (hpos == htot - 1) && (vpos == vtot - 1);
            vectors++;
            cmp("R3 hsync", hsync, e_run && hpos < Hs);
            cmp("R3 x", x, hx);
            cmp("R4 vsync", vsync, e_run && vpos < Vs);
            cmp("R4 y", y, vy);
            cmp("R5 de", de, e_de);
            cmp("R11 vsync_evt", vsync_evt, e_run && hpos == 0 && vpos == 0);
            cmp("R11 frame_start", frame_start, e_de && hx == 0 && vy == 0);
            cmp("R11 frame_end", frame_end, e_fe);
            cmp("R12 underflow", underflow, e_de && !pix_valid);
            cmp("R8 te_evt", te_evt, e_te);
            cmp("R6 busy", busy, m_st != 0);

            if (hsync) hs_run++;
            else if (hs_run > 0) begin last_hs = hs_run; hs_run = 0; end

            // next state, valid for the coming rising edge
            halt = halt_en && halt_in;
            launch = 0;
            nst = m_st;
            case (m_st)
                0: if (!cmd_mode) begin
                       if (run_en) launch = 1;
                   end else if (start_req) begin
                       if (te_gate_en) nst = 1; else launch = 1;
                   end
                1: if (e_te) launch = 1;
                2: if (e_fe) begin
                       if (lcmd != 0 || !run_en) nst = 0;
                       else if (halt) nst = 3;
                       else launch = 1;
                   end
                default: if (!halt) begin
                       if (run_en) launch = 1; else nst = 0;
                   end
            endcase
            if (e_run) begin
                hpos++;
                if (hpos == htot) begin
                    hpos = 0;
                    vpos++;
                    if (vpos == vtot) vpos = 0;
                end
            end
            if (launch) begin
                Hs = nz(h_timing & 255); Hb = nz((h_timing >> 8) & 4095); Hf = nz((h_timing >> 20) & 4095);
                Vs = nz(v_timing & 255); Vb = nz((v_timing >> 8) & 4095); Vf = nz((v_timing >> 20) & 4095);
                Ha = nz(panel_size & 32'hFFFF); Va = nz(panel_size >> 16);
                hpos = 0; vpos = 0; lcmd = cmd_mode; nst = 2;
            end
            m_st = nst;
            sel = te_from_pad ? te_pad : te_int;
            t3 = t2; t2 = t1; t1 = sel;
            if (rst) begin
                m_st = 0; hpos = 0; vpos = 0; lcmd = 0; t1 = 0; t2 = 0; t3 = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL R6 watchdog: got %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        panel_size = {16'd3, 16'd4};
        h_timing   = {12'd1, 12'd3, 8'd2};
        v_timing   = {12'd0, 12'd2, 8'd1};
        tick(3);
        rst = 0;
        tick(2);
        check_dir("R1 idle after reset", busy, 0);

        scen = "R6 continuous frames";
        run_en = 1;
        for (int i = 0; i < 160; i++) begin
            pix_valid = (i % 7) != 3;
            tick(1);
        end
        pix_valid = 1;

        scen = "R10 R2 reconfig mid-frame with zero fields";
        tick(20);
        panel_size = {16'd2, 16'd5};
        h_timing   = {12'd2, 12'd0, 8'd0};
        v_timing   = {12'd1, 12'd0, 8'd2};
        tick(160);
        check_dir("R2 zero sync field is one clock", last_hs, 1);

        scen = "R9 halt ignored without enable";
        halt_in = 1;
        tick(150);
        check_dir("R9 halt ignored, still running", busy, 1);

        scen = "R9 halt at frame boundary";
        halt_en = 1;
        tick(150);
        check_dir("R9 halted busy", busy, 1);
        check_dir("R9 halted hsync", hsync, 0);
        check_dir("R9 halted vsync", vsync, 0);
        halt_in = 0;
        tick(100);

        scen = "R6 stop";
        run_en = 0;
        tick(80);
        check_dir("R6 idle after run drop", busy, 0);

        scen = "R7 command single frame";
        halt_en = 0;
        cmd_mode = 1;
        start_req = 1; tick(1); start_req = 0;
        tick(80);
        check_dir("R7 idle after one frame", busy, 0);

        scen = "R8 pad TE gating";
        te_gate_en = 1; te_from_pad = 1;
        start_req = 1; tick(1); start_req = 0;
        tick(10);
        check_dir("R8 waiting busy", busy, 1);
        te_int = 1; tick(3); te_int = 0; tick(5);
        check_dir("R8 unselected source ignored", hsync | busy << 1, 2);
        te_pad = 1; tick(3); te_pad = 0;
        tick(80);
        check_dir("R8 idle after gated frame", busy, 0);

        scen = "R8 internal TE gating";
        te_from_pad = 0;
        start_req = 1; tick(1); start_req = 0;
        tick(6);
        te_int = 1; tick(2); te_int = 0;
        tick(80);

        scen = "R9 halt ignored in command mode";
        te_gate_en = 0; halt_en = 1; halt_in = 1;
        start_req = 1; tick(1); start_req = 0;
        tick(80);
        check_dir("R9 command frame ends idle", busy, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule